// File: doc/BRIEF.md
# Interline CCD Line and Field Timing Generator

This block derives all logic-level drive enables for an interline CCD from one free-running clock. The clock runs at twice the pixel-unit rate, and each unit is two clocks long. The first clock of a unit is the "H1 phase" and the second is the "H2 phase". A unit counter walks each line through these zones in order: horizontal blanking, dummy transfer bits, leading optical-black pixels, effective pixels, trailing optical-black pixels and an ignored tail. The block raises one flag per zone and issues a reset-gate pulse in every readout unit. It also opens a black-level clamp window over the trailing optical-black pixels.

A line counter groups lines into fields, and two fields make a frame. The odd field carries a fixed number of lines. The even field carries one extra dummy line placed directly after vertical blanking. Per field, the block provides the line number, a field flag, vertical line classification, a one-clock readout request and an electronic-shutter pulse train. The shutter pulse train has one pulse inside horizontal blanking on every line from field start up to a programmable line.

Two line-rate modes exist. In the first, every line is 1144 units. In the subcarrier-locked mode the nominal line is 1137.5 units, which is produced by alternating lines of 1137 and 1138 units. The mode input only takes effect at a frame boundary.

Top module: `ccd_timing_gen`

## Requirements
- R1: Each unit lasts two clocks, and `pix_cnt_o` advances only after the H2-phase clock. In mode 0 a line is 1144 units, so `line_start_o` recurs every 2288 clocks. After reset all counters, `field_o` and `mode_o` are 0.
- R2: In mode 1, line lengths alternate between 1137 and 1138 units. The first line of every frame is 1137 units, giving 2274 and 2276 clocks.
- R3: `h1_o` and `h2_o` are always complementary, and `h1_o` is high on the H1-phase clock of every unit. `rg_o` is high on the H1-phase clock of each readout unit (dummy through trailing optical black) and low elsewhere, giving 1044 pulses per line.
- R4: The zones of a line are as follows. Units 0 to HBLK-1 (default 88) are blanking. The next 28 are dummy, then 4 are leading optical black, 962 are effective, 50 are trailing optical black, and the remaining units are ignored. Exactly one of `hblank_o`, `pix_dummy_o`, `pix_fob_o`, `pix_eff_o`, `pix_rob_o` and `pix_ign_o` is high at any time.
- R5: `clamp_o` is high exactly during the trailing optical-black units of lines classed as optical black or effective. It is low on every other line.
- R6: A field with `field_o`=0 has VBLK+VFOB+VEFF+VROB lines, and a field with `field_o`=1 has one more line. `field_o` toggles at each field end, and `line_o` restarts at 0.
- R7: Lines below VBLK are vertical blanking. When `field_o`=1, line VBLK is the dummy line. The following lines are VFOB optical black, then VEFF effective, then VROB optical black, indicated on `vblank_o`, `vdummy_o`, `vob_o` and `veff_o`.
- R8: `readout_o` is a single clock pulse once per field, on line READ_LINE, at unit READ_POS, during the H1-phase clock.
- R9: `shut_line_i` is captured at each field end. In the next field, `shutter_o` is high for units SHUT_POS to SHUT_POS+SHUT_W-1 (default 8 to 23, inside blanking) on lines 0 to N-1. A value of 0 gives no pulses. Before the first field end the captured value is 0.
- R10: `mode_i` (0 = 1144-unit lines, 1 = alternating lines) is captured only at frame end and shown on `mode_o`. A change mid-frame alters no line of the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel-unit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Requested line-rate mode |
| shut_line_i | input | LINE_W | Line at which shutter pulses stop |
| h1_o | output | 1 | Horizontal transfer enable, phase 1 |
| h2_o | output | 1 | Horizontal transfer enable, phase 2 |
| rg_o | output | 1 | Reset-gate pulse |
| hblank_o | output | 1 | Horizontal blanking unit |
| pix_dummy_o | output | 1 | Dummy bit unit |
| pix_fob_o | output | 1 | Leading optical-black unit |
| pix_eff_o | output | 1 | Effective pixel unit |
| pix_rob_o | output | 1 | Trailing optical-black unit |
| pix_ign_o | output | 1 | Ignored tail unit |
| clamp_o | output | 1 | Black-level clamp window |
| line_start_o | output | 1 | First clock of a line |
| pix_cnt_o | output | UNIT_W | Unit position within the line |
| line_o | output | LINE_W | Line within the field |
| field_o | output | 1 | Field flag |
| vblank_o | output | 1 | Vertical blanking line |
| vdummy_o | output | 1 | Even-field dummy line |
| vob_o | output | 1 | Optical-black line |
| veff_o | output | 1 | Effective line |
| readout_o | output | 1 | Readout request pulse |
| shutter_o | output | 1 | Charge-drain shutter pulse |
| mode_o | output | 1 | Active line-rate mode |

## Verification
The bench keeps the true horizontal geometry of 1144 and 1137/1138 units, so every zone boundary and the ignored tail of both modes are checked exactly. The vertical counts shrink to VBLK=3, VFOB=2, VEFF=3, VROB=1 and READ_LINE=1. This gives 9-line and 10-line fields, which lets three frames run. Those three frames cover the even-field dummy line and shutter capture across field ends. They also cover a mode request placed mid-frame and the restart of line alternation at a frame boundary.

// File: rtl/ccdtg_pkg.sv
package ccdtg_pkg;

  typedef enum logic [2:0] {
    PR_BLANK, PR_DUMMY, PR_FOB, PR_EFF, PR_ROB, PR_IGN
  } pix_zone_e;

  typedef enum logic [1:0] {
    LZ_BLANK, LZ_DUMMY, LZ_OB, LZ_EFF
  } line_zone_e;

  // Units in the current line: fixed, or alternating short/long in mode 1.
  function automatic int unsigned line_units(logic alt_mode, logic long_line,
                                             int unsigned fixed_len,
                                             int unsigned short_len);
    if (!alt_mode) return fixed_len;
    return long_line ? short_len + 1 : short_len;
  endfunction

  // Horizontal zone of a unit position.
  function automatic pix_zone_e pix_zone(int unsigned u, int unsigned hblk,
                                         int unsigned ndum, int unsigned nfob,
                                         int unsigned neff, int unsigned nrob);
    int unsigned b_dum, b_fob, b_eff, b_rob;
    b_dum = hblk + ndum;
    b_fob = b_dum + nfob;
    b_eff = b_fob + neff;
    b_rob = b_eff + nrob;
    if (u < hblk)  return PR_BLANK;
    if (u < b_dum) return PR_DUMMY;
    if (u < b_fob) return PR_FOB;
    if (u < b_eff) return PR_EFF;
    if (u < b_rob) return PR_ROB;
    return PR_IGN;
  endfunction

  // Vertical class of a line; the even field inserts one dummy line.
  function automatic line_zone_e line_zone(int unsigned ln, logic even_f,
                                           int unsigned vblk, int unsigned vfob,
                                           int unsigned veff, int unsigned vrob);
    int unsigned off;
    if (ln < vblk) return LZ_BLANK;
    if (even_f && ln == vblk) return LZ_DUMMY;
    off = ln - vblk - (even_f ? 32'd1 : 32'd0);
    if (off < vfob) return LZ_OB;
    if (off < vfob + veff) return LZ_EFF;
    if (off < vfob + veff + vrob) return LZ_OB;
    return LZ_BLANK;
  endfunction

endpackage

// File: rtl/ccdtg_hcount.sv
module ccdtg_hcount #(
  parameter int unsigned UNIT_W    = 11,
  parameter int unsigned LEN_FIXED = 1144,
  parameter int unsigned LEN_SHORT = 1137
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_q,
  input  logic              frame_end,
  output logic              ph,
  output logic [UNIT_W-1:0] hcnt,
  output logic              line_end
);
  import ccdtg_pkg::*;

  logic        alt;
  int unsigned len;

  always_comb begin
    len      = line_units(mode_q, alt, LEN_FIXED, LEN_SHORT);
    line_end = ph && (32'(hcnt) == len - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= 1'b0;
      hcnt <= '0;
      alt  <= 1'b0;
    end else begin
      ph <= ~ph;
      if (ph) begin
        if (line_end) hcnt <= '0;
        else          hcnt <= hcnt + 1'b1;
      end
      if (line_end) alt <= frame_end ? 1'b0 : ~alt;
    end
  end

  AST_UNIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ph |=> $stable(hcnt)); // R1
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hcnt == '0)); // R1
  AST_ALT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !frame_end) |=> (alt != $past(alt))); // R2
  AST_ALT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && frame_end) |=> !alt); // R2

endmodule

// File: rtl/ccdtg_vcount.sv
module ccdtg_vcount #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned VBLK   = 16,
  parameter int unsigned VFOB   = 6,
  parameter int unsigned VEFF   = 236,
  parameter int unsigned VROB   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic              mode_i,
  output logic [LINE_W-1:0] vline,
  output logic              fld,
  output logic              mode_q,
  output logic              field_end,
  output logic              frame_end,
  output ccdtg_pkg::line_zone_e vzone
);
  import ccdtg_pkg::*;

  localparam int unsigned ODD_LINES  = VBLK + VFOB + VEFF + VROB;
  localparam int unsigned EVEN_LINES = ODD_LINES + 1;

  int unsigned flines;

  always_comb begin
    flines    = fld ? EVEN_LINES : ODD_LINES;
    field_end = line_end && (32'(vline) == flines - 1);
    frame_end = field_end && fld;
    vzone     = line_zone(32'(vline), fld, VBLK, VFOB, VEFF, VROB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vline  <= '0;
      fld    <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (line_end) vline <= field_end ? '0 : vline + 1'b1;
      if (field_end) fld <= ~fld;
      if (frame_end) mode_q <= mode_i;
    end
  end

  AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    field_end |=> (fld != $past(fld))); // R6
  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    field_end |=> (vline == '0)); // R6
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(mode_q)); // R10

endmodule

// File: rtl/ccdtg_hdecode.sv
module ccdtg_hdecode #(
  parameter int unsigned UNIT_W = 11,
  parameter int unsigned HBLK   = 88,
  parameter int unsigned NDUM   = 28,
  parameter int unsigned NFOB   = 4,
  parameter int unsigned NEFF   = 962,
  parameter int unsigned NROB   = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph,
  input  logic [UNIT_W-1:0] hcnt,
  input  logic              vactive,
  output logic              hblank,
  output logic              z_dummy,
  output logic              z_fob,
  output logic              z_eff,
  output logic              z_rob,
  output logic              z_ign,
  output logic              rg,
  output logic              clamp
);
  import ccdtg_pkg::*;

  pix_zone_e zone;
  logic      readout_unit;

  always_comb begin
    zone         = pix_zone(32'(hcnt), HBLK, NDUM, NFOB, NEFF, NROB);
    hblank       = (zone == PR_BLANK);
    z_dummy      = (zone == PR_DUMMY);
    z_fob        = (zone == PR_FOB);
    z_eff        = (zone == PR_EFF);
    z_rob        = (zone == PR_ROB);
    z_ign        = (zone == PR_IGN);
    readout_unit = !(hblank || z_ign);
    rg           = !ph && readout_unit;
    clamp        = z_rob && vactive;
  end

  AST_ZONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({hblank, z_dummy, z_fob, z_eff, z_rob, z_ign})); // R4
  AST_CLAMP_ROB: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |-> z_rob); // R5
  AST_RG_H1PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    rg |=> !rg); // R3

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen #(
  parameter int unsigned UNIT_W    = 11,
  parameter int unsigned LINE_W    = 10,
  parameter int unsigned LEN_FIXED = 1144,
  parameter int unsigned LEN_SHORT = 1137,
  parameter int unsigned HBLK      = 88,
  parameter int unsigned NDUM      = 28,
  parameter int unsigned NFOB      = 4,
  parameter int unsigned NEFF      = 962,
  parameter int unsigned NROB      = 50,
  parameter int unsigned VBLK      = 16,
  parameter int unsigned VFOB      = 6,
  parameter int unsigned VEFF      = 236,
  parameter int unsigned VROB      = 4,
  parameter int unsigned READ_LINE = 10,
  parameter int unsigned READ_POS  = 40,
  parameter int unsigned SHUT_POS  = 8,
  parameter int unsigned SHUT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic [LINE_W-1:0] shut_line_i,
  output logic              h1_o,
  output logic              h2_o,
  output logic              rg_o,
  output logic              hblank_o,
  output logic              pix_dummy_o,
  output logic              pix_fob_o,
  output logic              pix_eff_o,
  output logic              pix_rob_o,
  output logic              pix_ign_o,
  output logic              clamp_o,
  output logic              line_start_o,
  output logic [UNIT_W-1:0] pix_cnt_o,
  output logic [LINE_W-1:0] line_o,
  output logic              field_o,
  output logic              vblank_o,
  output logic              vdummy_o,
  output logic              vob_o,
  output logic              veff_o,
  output logic              readout_o,
  output logic              shutter_o,
  output logic              mode_o
);
  import ccdtg_pkg::*;

  localparam int unsigned SHUT_END = SHUT_POS + SHUT_W;

  logic              ph, line_end, field_end, frame_end, mode_q, fld, vactive;
  logic [UNIT_W-1:0] hcnt;
  logic [LINE_W-1:0] vline, shut_q;
  line_zone_e        vzone;

  ccdtg_hcount #(.UNIT_W(UNIT_W), .LEN_FIXED(LEN_FIXED), .LEN_SHORT(LEN_SHORT)) u_hcount (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .frame_end(frame_end),
    .ph(ph), .hcnt(hcnt), .line_end(line_end));

  ccdtg_vcount #(.LINE_W(LINE_W), .VBLK(VBLK), .VFOB(VFOB), .VEFF(VEFF), .VROB(VROB)) u_vcount (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .mode_i(mode_i),
    .vline(vline), .fld(fld), .mode_q(mode_q), .field_end(field_end),
    .frame_end(frame_end), .vzone(vzone));

  ccdtg_hdecode #(.UNIT_W(UNIT_W), .HBLK(HBLK), .NDUM(NDUM), .NFOB(NFOB),
                  .NEFF(NEFF), .NROB(NROB)) u_hdecode (
    .clk(clk), .rst_n(rst_n), .ph(ph), .hcnt(hcnt), .vactive(vactive),
    .hblank(hblank_o), .z_dummy(pix_dummy_o), .z_fob(pix_fob_o), .z_eff(pix_eff_o),
    .z_rob(pix_rob_o), .z_ign(pix_ign_o), .rg(rg_o), .clamp(clamp_o));

  // Shutter stop line is captured once per field.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shut_q <= '0;
    else if (field_end) shut_q <= shut_line_i;
  end

  always_comb begin
    vactive      = (vzone == LZ_OB) || (vzone == LZ_EFF);
    h1_o         = ~ph;
    h2_o         = ph;
    line_start_o = !ph && (hcnt == '0);
    pix_cnt_o    = hcnt;
    line_o       = vline;
    field_o      = fld;
    mode_o       = mode_q;
    vblank_o     = (vzone == LZ_BLANK);
    vdummy_o     = (vzone == LZ_DUMMY);
    vob_o        = (vzone == LZ_OB);
    veff_o       = (vzone == LZ_EFF);
    readout_o    = !ph && (32'(vline) == READ_LINE) && (32'(hcnt) == READ_POS);
    shutter_o    = (vline < shut_q) && (32'(hcnt) >= SHUT_POS) && (32'(hcnt) < SHUT_END);
  end

  AST_SHUT_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    shutter_o |-> hblank_o); // R9
  AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    readout_o |=> !readout_o); // R8
  AST_HPHASE_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    h1_o |=> h2_o); // R3

endmodule

// File: tb/tb_ccd_timing_gen.sv
module tb_ccd_timing_gen;
  localparam int VBLK = 3, VFOB = 2, VEFF = 3, VROB = 1;
  localparam int ODD_N = VBLK + VFOB + VEFF + VROB;

  logic clk = 1'b0, rst_n = 1'b0, mode_i = 1'b0;
  logic [9:0] shut_line_i = 10'd0;
  logic h1_o, h2_o, rg_o, hblank_o, pix_dummy_o, pix_fob_o, pix_eff_o, pix_rob_o, pix_ign_o;
  logic clamp_o, line_start_o, field_o, vblank_o, vdummy_o, vob_o, veff_o;
  logic readout_o, shutter_o, mode_o;
  logic [10:0] pix_cnt_o;
  logic [9:0]  line_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ccd_timing_gen #(.VBLK(VBLK), .VFOB(VFOB), .VEFF(VEFF), .VROB(VROB), .READ_LINE(1)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .shut_line_i(shut_line_i),
    .h1_o(h1_o), .h2_o(h2_o), .rg_o(rg_o), .hblank_o(hblank_o), .pix_dummy_o(pix_dummy_o),
    .pix_fob_o(pix_fob_o), .pix_eff_o(pix_eff_o), .pix_rob_o(pix_rob_o), .pix_ign_o(pix_ign_o),
    .clamp_o(clamp_o), .line_start_o(line_start_o), .pix_cnt_o(pix_cnt_o), .line_o(line_o),
    .field_o(field_o), .vblank_o(vblank_o), .vdummy_o(vdummy_o), .vob_o(vob_o),
    .veff_o(veff_o), .readout_o(readout_o), .shutter_o(shutter_o), .mode_o(mode_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench view of the vertical class: 0 blank, 1 dummy, 2 ob, 3 eff.
  function automatic int vclass(int ln, bit even);
    int off;
    if (ln < VBLK) return 0;
    if (even && ln == VBLK) return 1;
    off = ln - VBLK - (even ? 1 : 0);
    if (off < VFOB) return 2;
    if (off < VFOB + VEFF) return 3;
    if (off < VFOB + VEFF + VROB) return 2;
    return 0;
  endfunction

  // Monitors one whole field starting at its first clock (current negedge).
  task automatic run_field(input bit fexp, input int shut_n, input bit mexp, input int k0);
    int ln = 0, clk_in = 0, n_dum = 0, n_fob = 0, n_eff = 0, n_rob = 0, n_ign = 0, n_blk = 0;
    int n_rg = 0, n_clamp = 0, first_dum = -1, n_shut = 0, n_read = 0, bad_ph = 0, bad_shut = 0;
    int bad_len = 0, bad_zone = 0, bad_v = 0, bad_clamp = 0, bad_mode = 0, n_dummy_ln = 0;
    int vc = 0, len_exp, units, last_len = 0;
    bit fin;
    forever begin
      if (line_start_o && clk_in == 0) begin
        vc = vclass(ln, fexp);
        if (line_o != 10'(ln)) bad_v++;
        if ({vblank_o, vdummy_o, vob_o, veff_o} !=
            {vc == 0, vc == 1, vc == 2, vc == 3}) bad_v++;
        if (vc == 1) n_dummy_ln++;
        if (mode_o != mexp) bad_mode++;
      end
      if (h1_o == h2_o) bad_ph++;
      if (rg_o) n_rg++;
      if (readout_o) begin
        n_read++;
        if (line_o != 10'd1 || pix_cnt_o != 11'd40 || !h1_o) bad_v++;
      end
      if (shutter_o) begin
        n_shut++;
        if (!hblank_o || int'(line_o) >= shut_n || pix_cnt_o < 11'd8 || pix_cnt_o > 11'd23) bad_shut++;
      end
      if (h1_o) begin
        if (hblank_o) n_blk++;
        if (pix_dummy_o) begin n_dum++; if (first_dum < 0) first_dum = int'(pix_cnt_o); end
        if (pix_fob_o) n_fob++;
        if (pix_eff_o) n_eff++;
        if (pix_rob_o) n_rob++;
        if (pix_ign_o) n_ign++;
        if (clamp_o) n_clamp++;
      end
      clk_in++;
      @(negedge clk);
      fin = (field_o != fexp);
      if (line_start_o || fin) begin
        len_exp = mexp ? (((k0 + ln) % 2 == 0) ? 2274 : 2276) : 2288;
        units = len_exp / 2;
        if (clk_in != len_exp) begin bad_len++; last_len = clk_in; end
        if (n_blk != 88 || n_dum != 28 || n_fob != 4 || n_eff != 962 || n_rob != 50 ||
            n_ign != units - 1132 || first_dum != 88) bad_zone++;
        if (n_rg != 1044) bad_zone++;
        if (n_clamp != ((vc >= 2) ? 50 : 0)) bad_clamp++;
        ln++; clk_in = 0; n_blk = 0; n_dum = 0; n_fob = 0; n_eff = 0; n_rob = 0; n_ign = 0;
        n_rg = 0; n_clamp = 0; first_dum = -1;
      end
      if (fin) break;
    end
    chk(ln == ODD_N + (fexp ? 1 : 0), "R6 field line count", ln, ODD_N + (fexp ? 1 : 0));
    chk(bad_len == 0, mexp ? "R2 line length" : "R1 line length", last_len, 0);
    chk(bad_ph == 0, "R3 complementary phases", bad_ph, 0);
    chk(bad_zone == 0, "R4 zone counts and R3 rg pulses", bad_zone, 0);
    chk(bad_clamp == 0, "R5 clamp window", bad_clamp, 0);
    chk(bad_v == 0, "R7 vertical classes", bad_v, 0);
    chk(n_dummy_ln == (fexp ? 1 : 0), "R7 even-field dummy line", n_dummy_ln, fexp ? 1 : 0);
    chk(n_read == 1, "R8 readout pulse", n_read, 1);
    chk(n_shut == shut_n * 32 && bad_shut == 0, "R9 shutter pulses", n_shut, shut_n * 32);
    chk(bad_mode == 0, "R10 mode held", bad_mode, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(pix_cnt_o == 0 && line_o == 0, "R1 reset counters", int'(pix_cnt_o) + int'(line_o), 0);
    chk(field_o == 0 && mode_o == 0, "R1 reset field/mode", int'(field_o) + int'(mode_o), 0);
    chk(h1_o && !rg_o && hblank_o, "R3 reset outputs", int'({h1_o, rg_o, hblank_o}), 5);
    shut_line_i = 10'd5;
    rst_n = 1'b1;
  endtask

  task automatic t_frame1();
    fork
      run_field(1'b0, 0, 1'b0, 0);          // R9: nothing captured yet
      begin repeat (3000) @(negedge clk); mode_i = 1'b0; end
    join
    fork
      run_field(1'b1, 5, 1'b0, ODD_N);
      begin repeat (5000) @(negedge clk); shut_line_i = 10'd0; end  // R9 capture
    join
  endtask

  task automatic t_mode_switch();
    fork
      run_field(1'b0, 0, 1'b0, 0);
      begin repeat (4000) @(negedge clk); mode_i = 1'b1; shut_line_i = 10'd2; end  // R10
    join
    run_field(1'b1, 2, 1'b0, ODD_N);
    chk(mode_o == 1'b1, "R10 mode at frame start", int'(mode_o), 1);
    run_field(1'b0, 2, 1'b1, 0);              // R2 alternating lines
  endtask

  initial begin
    t_reset();
    t_frame1();
    t_mode_switch();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin repeat (180000) @(posedge clk); chk(1'b0, "watchdog", 0, 1); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule